// File: doc/BRIEF.md
# Prioritized UART Interrupt Controller

This block gathers the event sources of a UART into a single interrupt request line. It also produces a four-bit identification value that tells software which source is the most urgent one pending. The sources are: sticky line-error flags, received data (a full holding register in character mode, or a receive FIFO at or above its trigger level in FIFO mode), a character timeout on a stalled receive FIFO, a transmit holding register that has just become empty, and sticky modem-signal change flags. Each class of source has its own enable bit.

Each source is cleared by the register access that software uses to service it. Line errors clear when the line status register is read. Modem changes clear when the modem status register is read. The transmit-empty source clears when the transmit holding register is written, or when the identification value is read while transmit-empty is the source being reported. Received-data and timeout conditions follow the receive path and clear when the data is taken.

Every source state is registered. The identification value and the interrupt line are decoded from the registered source state and the enable bits, so a change on an event input shows at the outputs after one clock edge.

Top module: `uart_irq_prio`

## Requirements
- R1: After synchronous reset, `int_id` is 4'b0001 and `irq` is 0.
- R2: A pulse on any bit of `line_err_evt` with `irq_en[2]` set makes `int_id` 4'b0110 after one edge. The source stays pending until a `rd_line_stat` pulse clears it.
- R3: In character mode (`fifo_en`=0) with `irq_en[0]` set, `rx_hold_full`=1 makes `int_id` 4'b0100 after one edge. It clears one edge after `rx_hold_full` falls.
- R4: In FIFO mode the received-data source (4'b0100) is pending while `rx_level` is at or above the trigger selected by `rx_trig_sel`. The trigger is 1, DEPTH/4, DEPTH/2 or DEPTH-2 for select values 0 to 3, which gives 1, 4, 8 and 14 for a depth of 16.
- R5: In FIFO mode with `rx_level` nonzero, the timeout source (4'b1100) sets on the TIMEOUT_CHARS-th `char_tick` (default 4) that arrives with no `rx_push` or `rx_pop` in between. Any push or pop, or an empty FIFO, clears the source and restarts the count.
- R6: A rising edge of `thr_empty`, or `irq_en[1]` rising while `thr_empty` is 1, sets the transmit-empty source (4'b0010). A `thr_wr` pulse clears it.
- R7: An `rd_id` pulse clears the transmit-empty source only if that source is the one being reported in that cycle. Otherwise it stays pending.
- R8: A pulse on any bit of `modem_chg_evt` with `irq_en[3]` set gives 4'b0000 with `irq`=1. A `rd_modem_stat` pulse clears it.
- R9: When several sources are pending, `int_id` reports them in this order: line status first, then received data, then timeout, then transmit empty, then modem status.
- R10: A source whose enable bit is 0 is not reported, but its pending state is kept. It appears once the enable is set.
- R11: `irq` is 1 exactly when `int_id[0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 selects FIFO mode, 0 selects character mode |
| irq_en | input | 4 | Enables: [0] rx data/timeout, [1] tx empty, [2] line status, [3] modem status |
| line_err_evt | input | 4 | Receive error event pulses (overrun, parity, framing, break) |
| rd_line_stat | input | 1 | Line status register read strobe |
| rx_hold_full | input | 1 | Receive holding register full (character mode) |
| rx_level | input | 5 | Receive FIFO fill level |
| rx_trig_sel | input | 2 | Receive FIFO trigger select |
| rx_push | input | 1 | Receive FIFO write strobe |
| rx_pop | input | 1 | Receive FIFO read strobe |
| char_tick | input | 1 | One pulse per character time |
| thr_empty | input | 1 | Transmit holding register / FIFO empty |
| thr_wr | input | 1 | Transmit holding register write strobe |
| modem_chg_evt | input | 4 | Modem input change event pulses |
| rd_modem_stat | input | 1 | Modem status register read strobe |
| rd_id | input | 1 | Identification register read strobe |
| irq | output | 1 | Interrupt request |
| int_id | output | 4 | Identification value: [0]=1 no interrupt, [3:1] source code |

## Verification
Each source is first raised alone, so the code for each of the five sources is shown to be distinct and cleared only by its own strobe. The FIFO trigger is checked at one below and exactly at each of the four trigger levels, which would expose an off-by-one or a wrong select mapping. The timeout is checked with three and then four idle ticks, and with a push in the middle of the count. All sources are then raised together and removed one by one to check the priority order. Two further runs check the two rules that are easy to get wrong: an identification read while another source is shown must leave transmit-empty pending, and a masked source must keep its pending state until it is enabled.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    // identification values: bit 0 = 1 means nothing pending
    localparam logic [3:0] ID_NONE  = 4'b0001;
    localparam logic [3:0] ID_LINE  = 4'b0110;
    localparam logic [3:0] ID_RXD   = 4'b0100;
    localparam logic [3:0] ID_TOUT  = 4'b1100;
    localparam logic [3:0] ID_TX    = 4'b0010;
    localparam logic [3:0] ID_MODEM = 4'b0000;

    // enable bit positions
    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_LINE,
        SRC_RXD,
        SRC_TOUT,
        SRC_TX,
        SRC_MODEM
    } irq_src_e;

    typedef struct packed {
        logic line;
        logic rxd;
        logic tout;
        logic tx;
        logic modem;
    } irq_req_t;

    // trigger level for a given select value and FIFO depth
    function automatic int trig_level(input logic [1:0] sel, input int depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

    // fixed priority pick
    function automatic irq_src_e pick_source(input irq_req_t r);
        if (r.line)       return SRC_LINE;
        else if (r.rxd)   return SRC_RXD;
        else if (r.tout)  return SRC_TOUT;
        else if (r.tx)    return SRC_TX;
        else if (r.modem) return SRC_MODEM;
        else              return SRC_NONE;
    endfunction

    function automatic logic [3:0] id_of(input irq_src_e s);
        case (s)
            SRC_LINE:  return ID_LINE;
            SRC_RXD:   return ID_RXD;
            SRC_TOUT:  return ID_TOUT;
            SRC_TX:    return ID_TX;
            SRC_MODEM: return ID_MODEM;
            default:   return ID_NONE;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_sticky.sv
// Sticky event flags cleared by a status register read; a new event wins over the clear.
module uart_irq_sticky #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] evt,
    input  logic             clr,
    output logic             pend
);
    logic [WIDTH-1:0] flags;

    for (genvar i = 0; i < WIDTH; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (evt[i])
                flags[i] <= 1'b1;
            else if (clr)
                flags[i] <= 1'b0;
        end
    end

    assign pend = |flags;

    AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> pend);                                         // R2
    AST_STICKY_CLR: assert property (@(posedge clk) disable iff (rst)
        (clr && !(|evt)) |=> !pend);                              // R8
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pend && !clr) |=> pend);                                 // R10
endmodule

// File: rtl/uart_irq_rx.sv
// Received-data condition and character timeout.
module uart_irq_rx
    import uart_irq_pkg::*;
#(
    parameter int DEPTH         = 16,
    parameter int TIMEOUT_CHARS = 4,
    localparam int LVL_W        = $clog2(DEPTH + 1),
    localparam int CNT_W        = $clog2(TIMEOUT_CHARS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic             rx_hold_full,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [1:0]       rx_trig_sel,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             char_tick,
    output logic             rxd_pend,
    output logic             tout_pend
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CHARS - 1);

    logic             at_trig;
    logic             restart;
    logic [CNT_W-1:0] idle_cnt;

    always_comb begin
        at_trig = int'(rx_level) >= trig_level(rx_trig_sel, DEPTH);
        restart = !fifo_en || (rx_level == '0) || rx_push || rx_pop;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rxd_pend <= 1'b0;
        else
            rxd_pend <= fifo_en ? at_trig : rx_hold_full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt  <= '0;
            tout_pend <= 1'b0;
        end else if (restart) begin
            idle_cnt  <= '0;
            tout_pend <= 1'b0;
        end else if (char_tick) begin
            if (idle_cnt == CNT_LAST)
                tout_pend <= 1'b1;
            else
                idle_cnt <= idle_cnt + 1'b1;
        end
    end

    AST_TOUT_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(tout_pend) |-> $past(char_tick));                   // R5
    AST_TOUT_ACTIVITY_CLR: assert property (@(posedge clk) disable iff (rst)
        (rx_push || rx_pop) |=> !tout_pend);                      // R5
    AST_TOUT_FIFO_ONLY: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |=> !tout_pend);                                 // R5
    AST_RXD_CHAR_MODE: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |=> (rxd_pend == $past(rx_hold_full)));          // R3
endmodule

// File: rtl/uart_irq_tx.sv
// Transmit-empty source: set on becoming empty or on enable, cleared by write or reported read.
module uart_irq_tx (
    input  logic clk,
    input  logic rst,
    input  logic thr_empty,
    input  logic tx_en,
    input  logic thr_wr,
    input  logic rd_id,
    input  logic tx_shown,
    output logic tx_pend
);
    logic empty_q;
    logic en_q;
    logic set_c;
    logic clr_c;

    always_comb begin
        set_c = (thr_empty && !empty_q) || (tx_en && !en_q && thr_empty);
        clr_c = thr_wr || (rd_id && tx_shown);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_q <= 1'b1;
            en_q    <= 1'b0;
            tx_pend <= 1'b0;
        end else begin
            empty_q <= thr_empty;
            en_q    <= tx_en;
            if (clr_c)
                tx_pend <= 1'b0;
            else if (set_c)
                tx_pend <= 1'b1;
        end
    end

    AST_TX_WR_CLR: assert property (@(posedge clk) disable iff (rst)
        thr_wr |=> !tx_pend);                                     // R6
    AST_TX_READ_CLR: assert property (@(posedge clk) disable iff (rst)
        (rd_id && tx_shown) |=> !tx_pend);                        // R7
    AST_TX_READ_KEEP: assert property (@(posedge clk) disable iff (rst)
        (tx_pend && rd_id && !tx_shown && !thr_wr) |=> tx_pend);  // R7
    AST_TX_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_pend) |-> $past(thr_empty));                     // R6
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int DEPTH         = 16,
    parameter int TIMEOUT_CHARS = 4,
    parameter int N_LINE        = 4,
    parameter int N_MODEM       = 4,
    localparam int LVL_W        = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fifo_en,
    input  logic [3:0]         irq_en,
    input  logic [N_LINE-1:0]  line_err_evt,
    input  logic               rd_line_stat,
    input  logic               rx_hold_full,
    input  logic [LVL_W-1:0]   rx_level,
    input  logic [1:0]         rx_trig_sel,
    input  logic               rx_push,
    input  logic               rx_pop,
    input  logic               char_tick,
    input  logic               thr_empty,
    input  logic               thr_wr,
    input  logic [N_MODEM-1:0] modem_chg_evt,
    input  logic               rd_modem_stat,
    input  logic               rd_id,
    output logic               irq,
    output logic [3:0]         int_id
);
    logic     line_pend, modem_pend, rxd_pend, tout_pend, tx_pend;
    irq_req_t req;
    irq_src_e cur_src;
    logic     tx_shown;

    uart_irq_sticky #(.WIDTH(N_LINE)) u_line (
        .clk  (clk),
        .rst  (rst),
        .evt  (line_err_evt),
        .clr  (rd_line_stat),
        .pend (line_pend)
    );

    uart_irq_sticky #(.WIDTH(N_MODEM)) u_modem (
        .clk  (clk),
        .rst  (rst),
        .evt  (modem_chg_evt),
        .clr  (rd_modem_stat),
        .pend (modem_pend)
    );

    uart_irq_rx #(.DEPTH(DEPTH), .TIMEOUT_CHARS(TIMEOUT_CHARS)) u_rx (
        .clk          (clk),
        .rst          (rst),
        .fifo_en      (fifo_en),
        .rx_hold_full (rx_hold_full),
        .rx_level     (rx_level),
        .rx_trig_sel  (rx_trig_sel),
        .rx_push      (rx_push),
        .rx_pop       (rx_pop),
        .char_tick    (char_tick),
        .rxd_pend     (rxd_pend),
        .tout_pend    (tout_pend)
    );

    uart_irq_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .thr_empty (thr_empty),
        .tx_en     (irq_en[EN_TX]),
        .thr_wr    (thr_wr),
        .rd_id     (rd_id),
        .tx_shown  (tx_shown),
        .tx_pend   (tx_pend)
    );

    always_comb begin
        req.line  = line_pend  && irq_en[EN_LINE];
        req.rxd   = rxd_pend   && irq_en[EN_RX];
        req.tout  = tout_pend  && irq_en[EN_RX];
        req.tx    = tx_pend    && irq_en[EN_TX];
        req.modem = modem_pend && irq_en[EN_MODEM];
        cur_src   = pick_source(req);
        tx_shown  = (cur_src == SRC_TX);
        int_id    = id_of(cur_src);
        irq       = (cur_src != SRC_NONE);
    end

    AST_IRQ_MATCHES_ID: assert property (@(posedge clk) disable iff (rst)
        irq == !int_id[0]);                                       // R11
    AST_LINE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (line_pend && irq_en[EN_LINE]) |-> (int_id == ID_LINE));  // R9
    AST_MASKED_LINE_HIDDEN: assert property (@(posedge clk) disable iff (rst)
        !irq_en[EN_LINE] |-> (int_id != ID_LINE));                // R10
    AST_MODEM_LAST: assert property (@(posedge clk) disable iff (rst)
        (int_id == ID_MODEM) |-> (!rxd_pend || !irq_en[EN_RX]));  // R9
endmodule

// File: tb/uart_irq_prio_tb_top.sv
module uart_irq_prio_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_en = 1'b0;
    logic [3:0] irq_en = 4'h0;
    logic [3:0] line_err_evt = 4'h0;
    logic       rd_line_stat = 1'b0;
    logic       rx_hold_full = 1'b0;
    logic [4:0] rx_level = 5'd0;
    logic [1:0] rx_trig_sel = 2'd0;
    logic       rx_push = 1'b0;
    logic       rx_pop = 1'b0;
    logic       char_tick = 1'b0;
    logic       thr_empty = 1'b0;
    logic       thr_wr = 1'b0;
    logic [3:0] modem_chg_evt = 4'h0;
    logic       rd_modem_stat = 1'b0;
    logic       rd_id = 1'b0;
    logic       irq;
    logic [3:0] int_id;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    uart_irq_prio dut_i (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .irq_en(irq_en),
        .line_err_evt(line_err_evt), .rd_line_stat(rd_line_stat),
        .rx_hold_full(rx_hold_full), .rx_level(rx_level), .rx_trig_sel(rx_trig_sel),
        .rx_push(rx_push), .rx_pop(rx_pop), .char_tick(char_tick),
        .thr_empty(thr_empty), .thr_wr(thr_wr), .modem_chg_evt(modem_chg_evt),
        .rd_modem_stat(rd_modem_stat), .rd_id(rd_id), .irq(irq), .int_id(int_id)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [3:0] exp_id);
        n_chk++;
        if (int_id !== exp_id || irq !== !exp_id[0]) begin
            n_fail++;
            $display("FAIL %s: int_id=%b irq=%b expected int_id=%b irq=%b",
                     tag, int_id, irq, exp_id, !exp_id[0]);
        end
    endtask

    task automatic do_reset();
        fifo_en = 0; irq_en = 0; line_err_evt = 0; rd_line_stat = 0;
        rx_hold_full = 0; rx_level = 0; rx_trig_sel = 0; rx_push = 0; rx_pop = 0;
        char_tick = 0; thr_empty = 0; thr_wr = 0; modem_chg_evt = 0;
        rd_modem_stat = 0; rd_id = 0;
        rst = 1;
        step();
        step();
        rst = 0;
        step();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset state", 4'b0001);
    endtask

    task automatic t_line();
        do_reset();
        irq_en = 4'b0100;
        line_err_evt = 4'b0010; step(); line_err_evt = 0;
        chk("R2 line error set", 4'b0110);
        step();
        chk("R2 line error held", 4'b0110);
        rd_line_stat = 1; step(); rd_line_stat = 0;
        chk("R2 cleared by line status read", 4'b0001);
    endtask

    task automatic t_rx_hold();
        do_reset();
        irq_en = 4'b0001;
        rx_hold_full = 1; step();
        chk("R3 holding full", 4'b0100);
        rx_hold_full = 0; step();
        chk("R3 holding taken", 4'b0001);
    endtask

    task automatic t_fifo_trig();
        do_reset();
        irq_en = 4'b0001; fifo_en = 1;
        rx_trig_sel = 2'd0; rx_level = 5'd1; step();
        chk("R4 sel0 level1", 4'b0100);
        rx_trig_sel = 2'd1; rx_level = 5'd3; step();
        chk("R4 sel1 level3", 4'b0001);
        rx_level = 5'd4; step();
        chk("R4 sel1 level4", 4'b0100);
        rx_trig_sel = 2'd2; rx_level = 5'd7; step();
        chk("R4 sel2 level7", 4'b0001);
        rx_level = 5'd8; step();
        chk("R4 sel2 level8", 4'b0100);
        rx_trig_sel = 2'd3; rx_level = 5'd13; step();
        chk("R4 sel3 level13", 4'b0001);
        rx_level = 5'd14; step();
        chk("R4 sel3 level14", 4'b0100);
        fifo_en = 0; rx_hold_full = 0; step();
        chk("R3 character mode ignores level", 4'b0001);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            char_tick = 1; step(); char_tick = 0; step();
        end
    endtask

    task automatic t_timeout();
        do_reset();
        irq_en = 4'b0001; fifo_en = 1; rx_trig_sel = 2'd3; rx_level = 5'd2;
        step();
        ticks(3);
        chk("R5 three idle ticks", 4'b0001);
        ticks(1);
        chk("R5 fourth idle tick", 4'b1100);
        rx_pop = 1; step(); rx_pop = 0;
        chk("R5 pop clears timeout", 4'b0001);
        ticks(2);
        rx_push = 1; step(); rx_push = 0;
        ticks(3);
        chk("R5 push restarts count", 4'b0001);
        ticks(1);
        chk("R5 timeout after restart", 4'b1100);
        rx_level = 5'd0; step();
        chk("R5 empty fifo clears timeout", 4'b0001);
    endtask

    task automatic t_tx();
        do_reset();
        irq_en = 4'b0010;
        thr_empty = 1; step();
        chk("R6 became empty", 4'b0010);
        thr_wr = 1; thr_empty = 0; step(); thr_wr = 0;
        chk("R6 write clears", 4'b0001);
        thr_empty = 1; step();
        chk("R6 empty again", 4'b0010);
        rd_id = 1; step(); rd_id = 0;
        chk("R7 id read while shown clears", 4'b0001);
        irq_en = 4'b0000; step();
        irq_en = 4'b0010; step();
        chk("R6 enable rise while empty", 4'b0010);
    endtask

    task automatic t_tx_hidden_read();
        do_reset();
        irq_en = 4'b0110;
        line_err_evt = 4'b0001; thr_empty = 1; step(); line_err_evt = 0;
        chk("R9 line over tx", 4'b0110);
        rd_id = 1; step(); rd_id = 0;
        rd_line_stat = 1; step(); rd_line_stat = 0;
        chk("R7 tx kept after read of other id", 4'b0010);
    endtask

    task automatic t_modem();
        do_reset();
        irq_en = 4'b1000;
        modem_chg_evt = 4'b1000; step(); modem_chg_evt = 0;
        chk("R8 modem change", 4'b0000);
        rd_id = 1; step(); rd_id = 0;
        chk("R8 id read keeps modem", 4'b0000);
        rd_modem_stat = 1; step(); rd_modem_stat = 0;
        chk("R8 modem read clears", 4'b0001);
    endtask

    task automatic t_priority();
        do_reset();
        irq_en = 4'b1111;
        modem_chg_evt = 4'b0001; thr_empty = 1; rx_hold_full = 1; line_err_evt = 4'b0100;
        step();
        modem_chg_evt = 0; line_err_evt = 0;
        chk("R9 all pending shows line", 4'b0110);
        rd_line_stat = 1; step(); rd_line_stat = 0;
        chk("R9 rx data next", 4'b0100);
        rx_hold_full = 0; step();
        chk("R9 tx next", 4'b0010);
        rd_id = 1; step(); rd_id = 0;
        chk("R9 modem last", 4'b0000);
        rd_modem_stat = 1; step(); rd_modem_stat = 0;
        chk("R9 nothing left", 4'b0001);
        fifo_en = 1; rx_trig_sel = 2'd3; rx_level = 5'd1; step();
        ticks(4);
        thr_wr = 1; step(); thr_wr = 0;
        thr_empty = 0; step(); thr_empty = 1; step();
        chk("R9 timeout over tx", 4'b1100);
    endtask

    task automatic t_mask();
        do_reset();
        irq_en = 4'b0000;
        line_err_evt = 4'b1000; step(); line_err_evt = 0;
        chk("R10 masked line hidden", 4'b0001);
        irq_en = 4'b0100; step();
        chk("R10 pending shown after enable", 4'b0110);
        irq_en = 4'b0000; rx_hold_full = 1; step();
        chk("R10 masked rx hidden", 4'b0001);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        t_reset();
        t_line();
        t_rx_hold();
        t_fifo_trig();
        t_timeout();
        t_tx();
        t_tx_hidden_read();
        t_modem();
        t_priority();
        t_mask();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule